// File: doc/BRIEF.md
# Eight-Channel Periodic Interrupt Timer

This block is a bank of eight independent 32-bit down-counters behind a small register bus. Each counter is stepped by a shared timer tick. It counts down from a programmable start value and, on the step taken at zero, returns to that start value and sets a sticky expiry flag. Software clears the flag by writing a one to it. Each channel drives its own interrupt line while its flag is set and its interrupt enable is on. Any channel other than the first can be linked to the channel below it, so that it steps once per expiry of that lower channel rather than once per tick. Linking channel 1 to channel 0 forms a 64-bit count. That count is read as two words, and the read of the upper word captures the lower word so that the pair is coherent.

A global control register can stop every counter at once. It can also freeze the counters while the debug-halt input is high. The bus is a plain request interface with no stall. A write takes effect at the clock edge on which it is presented. Read data and its valid strobe appear one cycle after the read request, and the bus never applies back-pressure.

Top module: `ptmr_bank`

## Requirements
- R1: After reset every register reads 0 (global control, all load, count, control and flag words, both 64-bit count words) and every interrupt line is low.
- R2: Writing a channel control word whose bit 0 (enable) is 1 while enable was 0 copies the load word (channel offset +0x0) into the count (+0x4) at that write's clock edge.
- R3: A channel steps only while it is enabled and running. A step on a nonzero count subtracts one. A step on a zero count reloads the load word and sets flag bit 0 (+0xC), so with load L the flag sets on the (L+1)-th step after enabling.
- R4: Writing a 1 to flag bit 0 clears the flag, and writing a 0 leaves it unchanged. When an expiry and a clearing write fall in the same cycle, the flag ends up set.
- R5: Interrupt line n is high exactly while channel n's flag is set and bit 1 of its control word (+0x8) is 1.
- R6: With control bit 2 set, a channel n>0 steps once per expiry of channel n-1 and ignores the tick. Channel 0 ignores bit 2.
- R7: Global control word (0x000) bit 1 stops all counters. Bit 0 stops them only while debug_halt is high.
- R8: Reading 0x0E0 returns channel 1's count and captures channel 0's count. Reading 0x0E4 returns the captured value.
- R9: Channel n occupies 0x120+0x10*n. The count word is read-only (writes are ignored). Unmapped addresses read 0. Read data is valid in the cycle after the request, flagged by bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer step strobe for unlinked channels |
| debug_halt | input | 1 | Debug halt; freezes counters when enabled |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq | output | 8 | Per-channel interrupt lines |

## Verification
Two functions can meet in one cycle. The first is a channel expiring on a tick. The second is a software write of one to that channel's flag. The bench steps channel 0 down to zero with its flag already set, then presents the clearing write and the tick on the same edge. It judges the result by reading the flag back, which must still be 1. A second coincidence is a lifetime upper-word read paired with a later tick that moves channel 0: the lower-word read must return the count from the time of the upper read, not the moved one.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned CH_BASE   = 12'h120;
  localparam int unsigned CH_STRIDE = 16;
  localparam int unsigned GCTL_ADDR = 12'h000;
  localparam int unsigned LIFE_HI   = 12'h0E0;
  localparam int unsigned LIFE_LO   = 12'h0E4;

  typedef enum logic [2:0] {
    K_NONE, K_GCTL, K_LHI, K_LLO, K_LOAD, K_CNT, K_CTL, K_FLG
  } reg_kind_e;

  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_IE    = 1;
  localparam int unsigned CTL_CHAIN = 2;
endpackage

// File: rtl/ptmr_decode.sv
module ptmr_decode import ptmr_pkg::*; #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned CH_END = CH_BASE + N_CH * CH_STRIDE;

  logic [ADDR_W-1:0] off;
  logic              in_ch;

  always_comb begin
    off   = addr - ADDR_W'(CH_BASE);
    in_ch = (32'(addr) >= CH_BASE) && (32'(addr) < CH_END);
    kind  = K_NONE;
    idx   = IDX_W'(off >> 4);
    if (addr[1:0] == 2'b00) begin
      if (32'(addr) == GCTL_ADDR)     kind = K_GCTL;
      else if (32'(addr) == LIFE_HI)  kind = K_LHI;
      else if (32'(addr) == LIFE_LO)  kind = K_LLO;
      else if (in_ch) begin
        unique case (off[3:2])
          2'd0: kind = K_LOAD;
          2'd1: kind = K_CNT;
          2'd2: kind = K_CTL;
          default: kind = K_FLG;
        endcase
      end
    end
  end
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel import ptmr_pkg::*; #(
  parameter int unsigned CNT_W   = 32,
  parameter bit          CHAIN_OK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             prev_exp,
  input  logic             wr_load,
  input  logic             wr_ctl,
  input  logic             wr_flg,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [2:0]       ctl_q,
  output logic             flag_q,
  output logic             expire,
  output logic             irq
);
  logic step_src, step_ok, en_rise, clr;

  always_comb begin
    step_src = (CHAIN_OK && ctl_q[CTL_CHAIN]) ? prev_exp : tick;
    step_ok  = run && ctl_q[CTL_EN] && step_src;
    en_rise  = wr_ctl && wdata[CTL_EN] && !ctl_q[CTL_EN];
    expire   = step_ok && (cnt_q == '0);
    clr      = wr_flg && wdata[0];
    irq      = flag_q && ctl_q[CTL_IE];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_ctl)  ctl_q  <= wdata[2:0];
      if (en_rise)      cnt_q <= load_q;
      else if (expire)  cnt_q <= load_q;
      else if (step_ok) cnt_q <= cnt_q - 1'b1;
      if (expire)   flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && cnt_q != '0 && !en_rise) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r3_reload_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr_load) |=> (flag_q && cnt_q == $past(load_q)));
  a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && !wr_load) |=> (cnt_q == $past(load_q)));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !expire) |=> !flag_q);
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && expire) |=> flag_q);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !en_rise) |=> $stable(cnt_q));
endmodule

// File: rtl/ptmr_readback.sv
module ptmr_readback import ptmr_pkg::*; #(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd,
  input  reg_kind_e                  kind,
  input  logic [IDX_W-1:0]           idx,
  input  logic [1:0]                 gctl,
  input  logic [N_CH-1:0][CNT_W-1:0] loads,
  input  logic [N_CH-1:0][CNT_W-1:0] cnts,
  input  logic [N_CH-1:0][2:0]       ctls,
  input  logic [N_CH-1:0]            flags,
  output logic [CNT_W-1:0]           rdata,
  output logic                       rvalid
);
  logic [CNT_W-1:0] low_lat, mux;

  always_comb begin
    mux = '0;
    unique case (kind)
      K_GCTL: mux = CNT_W'(gctl);
      K_LHI:  mux = cnts[1];
      K_LLO:  mux = low_lat;
      K_LOAD: mux = loads[idx];
      K_CNT:  mux = cnts[idx];
      K_CTL:  mux = CNT_W'(ctls[idx]);
      K_FLG:  mux = CNT_W'(flags[idx]);
      default: mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      rvalid  <= 1'b0;
      low_lat <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= mux;
      if (rd && kind == K_LHI) low_lat <= cnts[0];
    end
  end

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && kind == K_LHI) |=> (low_lat == $past(cnts[0])));
  a_r9_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
endmodule

// File: rtl/ptmr_bank.sv
module ptmr_bank import ptmr_pkg::*; #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              debug_halt,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic [N_CH-1:0]   irq
);
  reg_kind_e  kind;
  logic [IDX_W-1:0] idx;
  logic frz_q, mdis_q, run, wr, rd;

  logic [N_CH-1:0][CNT_W-1:0] loads, cnts;
  logic [N_CH-1:0][2:0]       ctls;
  logic [N_CH-1:0]            flags;

  ptmr_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .kind(kind), .idx(idx)
  );

  always_comb begin
    wr  = bus_req && bus_we;
    rd  = bus_req && !bus_we;
    run = !mdis_q && !(frz_q && debug_halt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz_q  <= 1'b0;
      mdis_q <= 1'b0;
    end else if (wr && kind == K_GCTL) begin
      frz_q  <= bus_wdata[0];
      mdis_q <= bus_wdata[1];
    end
  end

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic exp_o, prev;
    logic sel;
    assign sel = (32'(idx) == n);
    if (n == 0) begin : g_first
      assign prev = 1'b0;
    end else begin : g_rest
      assign prev = g_ch[n-1].exp_o;
    end
    ptmr_channel #(.CNT_W(CNT_W), .CHAIN_OK(n != 0)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .prev_exp(prev),
      .wr_load(wr && sel && kind == K_LOAD),
      .wr_ctl (wr && sel && kind == K_CTL),
      .wr_flg (wr && sel && kind == K_FLG),
      .wdata(bus_wdata),
      .load_q(loads[n]), .cnt_q(cnts[n]), .ctl_q(ctls[n]), .flag_q(flags[n]),
      .expire(exp_o), .irq(irq[n])
    );
  end

  ptmr_readback #(.N_CH(N_CH), .CNT_W(CNT_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd(rd), .kind(kind), .idx(idx),
    .gctl({mdis_q, frz_q}), .loads(loads), .cnts(cnts), .ctls(ctls),
    .flags(flags), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  a_r1_irq_reset: assert property (@(posedge clk)
    !rst_n |=> (irq == '0));
  a_r7_disable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mdis_q && !(wr && kind == K_CTL)) |=> $stable(cnts));
endmodule

// File: tb/sim_ptmr_bank.sv
module sim_ptmr_bank;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, debug_halt = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [7:0] irq;

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  ptmr_bank u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .debug_halt(debug_halt),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq(irq));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected rvalid", 32'h1, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", 32'(cycles), 32'd100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] e,
                          input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick = 1'b1;
      @(posedge clk); #1; tick = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic [7:0] e, input string t);
    @(negedge clk);
    check(irq === e, t, 32'(irq), 32'(e));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_irq(8'h00, "R1 irq after reset");
    bus_read(12'h000, 0, "R1 global control");
    bus_read(12'h190, 0, "R1 ch7 load");
    bus_read(12'h128, 0, "R1 ch0 control");
    bus_read(12'h13C, 0, "R1 ch1 flag");
    bus_read(12'h0E0, 0, "R1 lifetime high");
    bus_read(12'h0E4, 0, "R1 lifetime low");

    // R2/R3 basic countdown on ch0, load 5
    bus_write(12'h120, 5);
    bus_write(12'h128, 1);
    bus_read(12'h124, 5, "R2 enable loads count");
    ticks(3);
    bus_read(12'h124, 2, "R3 three steps");
    ticks(2);
    bus_read(12'h124, 0, "R3 reached zero");
    bus_read(12'h12C, 0, "R3 no flag at zero");
    ticks(1);
    bus_read(12'h124, 5, "R3 reload on step at zero");
    bus_read(12'h12C, 1, "R3 flag after L+1 steps");
    chk_irq(8'h00, "R5 irq masked");
    bus_write(12'h128, 3);
    chk_irq(8'h01, "R5 irq enabled");
    bus_write(12'h12C, 0);
    bus_read(12'h12C, 1, "R4 write zero keeps flag");
    bus_write(12'h12C, 1);
    bus_read(12'h12C, 0, "R4 write one clears");
    chk_irq(8'h00, "R5 irq drops with flag");

    // R4 clear and expiry in the same cycle
    ticks(6);
    ticks(5);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h12C; bus_wdata = 1; tick = 1'b1;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0; tick = 1'b0;
    bus_read(12'h12C, 1, "R4 expiry beats clear");
    bus_read(12'h124, 5, "R3 reload at collision");
    bus_write(12'h12C, 1);

    // R6 chaining ch1 onto ch0
    bus_write(12'h128, 0);
    bus_write(12'h120, 1);
    bus_write(12'h128, 1);
    bus_write(12'h130, 2);
    bus_write(12'h138, 5);
    ticks(4);
    bus_read(12'h134, 0, "R6 ch1 after two ch0 expiries");
    bus_read(12'h124, 1, "R6 ch0 count");
    ticks(2);
    bus_read(12'h134, 2, "R6 ch1 reload");
    bus_read(12'h13C, 1, "R6 ch1 flag");
    bus_write(12'h128, 5);
    ticks(1);
    bus_read(12'h124, 0, "R6 ch0 ignores chain bit");

    // R8 coherent lifetime read
    bus_read(12'h0E0, 2, "R8 high word");
    ticks(1);
    bus_read(12'h0E4, 0, "R8 low word captured");
    bus_read(12'h0E0, 1, "R8 high word second");
    bus_read(12'h0E4, 1, "R8 low word second");

    // R7 global disable and freeze
    bus_write(12'h000, 2);
    bus_read(12'h000, 2, "R7 control readback");
    ticks(3);
    bus_read(12'h124, 1, "R7 disable holds");
    bus_write(12'h000, 1);
    debug_halt = 1'b1;
    ticks(1);
    bus_read(12'h124, 1, "R7 freeze under halt");
    debug_halt = 1'b0;
    ticks(1);
    bus_read(12'h124, 0, "R7 freeze without halt counts");
    bus_write(12'h000, 0);

    // R9 map details
    bus_write(12'h124, 32'h77);
    bus_read(12'h124, 0, "R9 count is read-only");
    bus_read(12'h1A0, 0, "R9 unmapped reads zero");
    bus_read(12'h138, 5, "R9 ch1 control readback");
    bus_write(12'h190, 9);
    bus_write(12'h198, 1);
    bus_read(12'h194, 9, "R2 ch7 enable loads");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) check(1'b0, "R9 missing read data", 32'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule